// File: doc/BRIEF.md
# Capability Bounds Access Checker

This block sits in the execute stage and decides whether a load, store or fetch may proceed when its base register holds a capability. The capability arrives split into fields: a validity bit, an inclusive lower bound, an exclusive upper bound, a permission mask and an object type. The access arrives as an effective address, a size in bytes and an operation kind. The block works out the verdict with combinational logic and presents it through a single register stage. The result appears one cycle after the request.

The checks are ranked, and the block reports only the highest-ranked one that fails. Validity comes first, then both bounds, then sealing, then permission. The verdict does not depend on address translation or page attributes. A fault reported here stops the access before translation starts, even when the target page is mapped and writable.

The bounds arithmetic carries one extra bit. An access that would wrap past the top of the address space therefore fails instead of landing back at low addresses.

Top module: `cap_access_checker`

## Requirements
- R1: The result (`res_valid_o`, `pass_o`, `cause_o`) appears exactly one clock after a cycle with `req_valid_i` high. `pass_o` is high exactly when `cause_o` is 3'd0. In a cycle where `res_valid_o` is low, `pass_o` is 0 and `cause_o` is 3'd0.
- R2: A request whose `cap_tag_i` is 0 reports cause 3'd1 (tag violation), whatever the other fields hold.
- R3: A tagged request with `addr_i` below `cap_base_i` reports cause 3'd2 (length violation).
- R4: The upper check compares `addr_i + size_i` against `cap_top_i`, and the top is exclusive. An access whose last byte is `cap_top_i - 1` passes this check. An access that starts inside the bounds and runs one byte further reports cause 3'd2.
- R5: `addr_i + size_i` is formed one bit wider than the address. A sum that wraps past the top of the address space reports cause 3'd2.
- R6: A tagged, in-bounds request with a nonzero `cap_otype_i` reports cause 3'd3 (seal violation) for op codes 0 to 3. A fetch (op code 3'd4) is not subject to the seal check.
- R7: The permission mask bits are: bit 0 load, bit 1 store, bit 2 execute, bit 3 load-capability, bit 4 store-capability. The op codes are: 3'd0 data load, 3'd1 data store, 3'd2 capability load, 3'd3 capability store, 3'd4 fetch. A data load needs bit 0, a data store needs bit 1 and a fetch needs bit 2. Op codes 3'd5 to 3'd7 always fail. Any missing permission reports cause 3'd4.
- R8: A capability load needs both bit 0 and bit 3. A capability store needs both bit 1 and bit 4. With either bit missing, the request reports cause 3'd4.
- R9: When several checks fail, the reported cause follows the order tag, bounds, seal, permission.
- R10: While `rst_ni` is low, `res_valid_o`, `pass_o` and `cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| cap_tag_i | input | 1 | Capability validity bit |
| cap_base_i | input | ADDR_W | Inclusive lower bound |
| cap_top_i | input | ADDR_W | Exclusive upper bound |
| cap_perms_i | input | 5 | Permission mask |
| cap_otype_i | input | OTYPE_W | Object type; nonzero means sealed |
| addr_i | input | ADDR_W | Effective address |
| size_i | input | SIZE_W | Access size in bytes |
| op_i | input | 3 | Operation kind |
| res_valid_o | output | 1 | Result valid |
| pass_o | output | 1 | Access allowed |
| cause_o | output | 3 | First failing cause; 0 means pass |

## Verification
The bench probes the exact upper edge: an access ending at the top must pass, and one byte more must fail. A checker that ignored the access size, or treated the top as inclusive, would get one of these two wrong. A near-top access whose sum wraps exposes an adder without the extra bit, because the wrapped sum looks in bounds. Requests that fail several checks at once, such as untagged, sealed and out of bounds together, would reveal a wrong priority order. A sealed fetch and partial permission masks on capability loads and stores catch a seal check applied too widely and a permission test that looks at only one of the two required bits.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

  localparam int PERM_W   = 5;
  localparam int PB_LOAD  = 0;
  localparam int PB_STORE = 1;
  localparam int PB_EXEC  = 2;
  localparam int PB_LDCAP = 3;
  localparam int PB_STCAP = 4;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_CLOAD  = 3'd2,
    OP_CSTORE = 3'd3,
    OP_FETCH  = 3'd4
  } cap_op_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TAG  = 3'd1,
    CAUSE_LEN  = 3'd2,
    CAUSE_SEAL = 3'd3,
    CAUSE_PERM = 3'd4
  } cap_cause_e;

endpackage

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              below_base_o,
  output logic              above_top_o
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] end_addr;

  // extra bit keeps a wrapped end address above any top
  assign end_addr     = {1'b0, addr_i} + SUM_W'(size_i);
  assign below_base_o = addr_i < base_i;
  assign above_top_o  = end_addr > {1'b0, top_i};

endmodule

// File: rtl/cap_perm_chk.sv
module cap_perm_chk #(
  parameter int OTYPE_W = 4
) (
  input  logic [cap_chk_pkg::PERM_W-1:0] perms_i,
  input  logic [OTYPE_W-1:0]             otype_i,
  input  logic [2:0]                     op_i,
  output logic                           seal_fail_o,
  output logic                           perm_fail_o
);
  import cap_chk_pkg::*;

  logic [PERM_W-1:0] need;
  logic              bad_op;
  logic              is_mem;

  always_comb begin
    need   = '0;
    bad_op = 1'b0;
    is_mem = 1'b1;
    case (op_i)
      OP_LOAD:   need[PB_LOAD] = 1'b1;
      OP_STORE:  need[PB_STORE] = 1'b1;
      OP_CLOAD: begin
        need[PB_LOAD]  = 1'b1;
        need[PB_LDCAP] = 1'b1;
      end
      OP_CSTORE: begin
        need[PB_STORE] = 1'b1;
        need[PB_STCAP] = 1'b1;
      end
      OP_FETCH: begin
        need[PB_EXEC] = 1'b1;
        is_mem        = 1'b0;
      end
      default: begin
        bad_op = 1'b1;
        is_mem = 1'b0;
      end
    endcase
  end

  assign seal_fail_o = is_mem && (|otype_i);
  assign perm_fail_o = bad_op || ((perms_i & need) != need);

endmodule

// File: rtl/cap_cause_sel.sv
module cap_cause_sel (
  input  logic       tag_i,
  input  logic       below_base_i,
  input  logic       above_top_i,
  input  logic       seal_fail_i,
  input  logic       perm_fail_i,
  output logic [2:0] cause_o
);
  import cap_chk_pkg::*;

  cap_cause_e cause;

  always_comb begin
    if (!tag_i)                           cause = CAUSE_TAG;
    else if (below_base_i || above_top_i) cause = CAUSE_LEN;
    else if (seal_fail_i)                 cause = CAUSE_SEAL;
    else if (perm_fail_i)                 cause = CAUSE_PERM;
    else                                  cause = CAUSE_NONE;
  end

  assign cause_o = cause;

endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 5,
  parameter int OTYPE_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic                           cap_tag_i,
  input  logic [ADDR_W-1:0]              cap_base_i,
  input  logic [ADDR_W-1:0]              cap_top_i,
  input  logic [cap_chk_pkg::PERM_W-1:0] cap_perms_i,
  input  logic [OTYPE_W-1:0]             cap_otype_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [SIZE_W-1:0]              size_i,
  input  logic [2:0]                     op_i,
  output logic                           res_valid_o,
  output logic                           pass_o,
  output logic [2:0]                     cause_o
);
  logic       below_base, above_top, seal_fail, perm_fail;
  logic [2:0] cause_d;

  cap_bounds_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_bounds (
    .base_i       (cap_base_i),
    .top_i        (cap_top_i),
    .addr_i       (addr_i),
    .size_i       (size_i),
    .below_base_o (below_base),
    .above_top_o  (above_top)
  );

  cap_perm_chk #(.OTYPE_W(OTYPE_W)) i_perm (
    .perms_i     (cap_perms_i),
    .otype_i     (cap_otype_i),
    .op_i        (op_i),
    .seal_fail_o (seal_fail),
    .perm_fail_o (perm_fail)
  );

  cap_cause_sel i_sel (
    .tag_i        (cap_tag_i),
    .below_base_i (below_base),
    .above_top_i  (above_top),
    .seal_fail_i  (seal_fail),
    .perm_fail_i  (perm_fail),
    .cause_o      (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      pass_o      <= 1'b0;
      cause_o     <= 3'd0;
    end else begin
      res_valid_o <= req_valid_i;
      pass_o      <= req_valid_i && (cause_d == 3'd0);
      cause_o     <= req_valid_i ? cause_d : 3'd0;
    end
  end

endmodule

// File: rtl/cap_access_checker_sva.sv
module cap_access_checker_sva #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 5,
  parameter int OTYPE_W = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic                           cap_tag_i,
  input logic [ADDR_W-1:0]              cap_base_i,
  input logic [ADDR_W-1:0]              cap_top_i,
  input logic [cap_chk_pkg::PERM_W-1:0] cap_perms_i,
  input logic [OTYPE_W-1:0]             cap_otype_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [SIZE_W-1:0]              size_i,
  input logic [2:0]                     op_i,
  input logic                           res_valid_o,
  input logic                           pass_o,
  input logic [2:0]                     cause_o
);
  logic [ADDR_W:0] acc_end;
  logic            in_bounds;

  assign acc_end   = {1'b0, addr_i} + (ADDR_W+1)'(size_i);
  assign in_bounds = (addr_i >= cap_base_i) && (acc_end <= {1'b0, cap_top_i});

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o); // R1
  AST_PASS_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (pass_o == (cause_o == 3'd0))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!pass_o && cause_o == 3'd0)); // R1
  AST_TAG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cap_tag_i) |=> cause_o == 3'd1); // R2
  AST_BELOW_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && addr_i < cap_base_i) |=> cause_o == 3'd2); // R3
  AST_PAST_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && acc_end > {1'b0, cap_top_i}) |=> cause_o == 3'd2); // R4
  AST_SEALED_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && in_bounds && cap_otype_i != '0 && op_i < 3'd4)
    |=> cause_o == 3'd3); // R6
  AST_CAUSE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o <= 3'd4); // R9

endmodule

bind cap_access_checker cap_access_checker_sva #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OTYPE_W(OTYPE_W)
) i_sva (.*);

// File: tb/test_cap_access_checker.sv
module test_cap_access_checker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 5;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          cap_tag = 1'b0;
  logic [AW-1:0] cap_base = '0;
  logic [AW-1:0] cap_top = '0;
  logic [4:0]    cap_perms = '0;
  logic [OW-1:0] cap_otype = '0;
  logic [AW-1:0] addr = '0;
  logic [SW-1:0] size = '0;
  logic [2:0]    op = '0;
  logic          res_valid, pass;
  logic [2:0]    cause;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_access_checker #(.ADDR_W(AW), .SIZE_W(SW), .OTYPE_W(OW)) i_cap_access_checker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .cap_tag_i(cap_tag),
    .cap_base_i(cap_base), .cap_top_i(cap_top), .cap_perms_i(cap_perms),
    .cap_otype_i(cap_otype), .addr_i(addr), .size_i(size), .op_i(op),
    .res_valid_o(res_valid), .pass_o(pass), .cause_o(cause)
  );

  task automatic drive(input logic t, input logic [AW-1:0] b, input logic [AW-1:0] tp,
                       input logic [4:0] pm, input logic [OW-1:0] ot, input logic [AW-1:0] a,
                       input logic [SW-1:0] sz, input logic [2:0] o, input int exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; cap_tag = t; cap_base = b; cap_top = tp; cap_perms = pm;
    cap_otype = ot; addr = a; size = sz; op = o;
    exp_q.push_back(exp);
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: latency and scoreboard compare
  initial begin
    logic sent;
    int   e;
    string r;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      sent = req_valid;
      #1;
      checks++;
      if (res_valid !== sent) begin
        errors++;
        $display("FAIL R1 latency: res_valid=%0b expected %0b", res_valid, sent);
      end
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result: cause=%0d expected none", cause);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          checks++;
          if (cause !== 3'(e) || pass !== (e == 0)) begin
            errors++;
            $display("FAIL %s: cause=%0d pass=%0b expected cause=%0d pass=%0b",
                     r, cause, pass, e, (e == 0));
          end
        end
      end else if (pass !== 1'b0 || cause !== 3'd0) begin
        errors++;
        $display("FAIL R1 idle: pass=%0b cause=%0d expected 0 0", pass, cause);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    checks++; // R10
    if (res_valid !== 1'b0 || pass !== 1'b0 || cause !== 3'd0) begin
      errors++;
      $display("FAIL R10 reset: v=%0b p=%0b c=%0d expected 0 0 0", res_valid, pass, cause);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // base 0x1000, top 0x1100 exclusive
    drive(1, 32'h1000, 32'h1100, 5'h1F, 0, 32'h1000, 4, 3'd0, 0, "R1 in-bounds load");
    drive(0, 32'h1000, 32'h1100, 5'h00, 3, 32'h0800, 4, 3'd1, 1, "R2 R9 untagged with all faults");
    drive(0, 32'h1000, 32'h1100, 5'h1F, 0, 32'h1000, 4, 3'd0, 1, "R2 untagged otherwise fine");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 0, 32'h0FFF, 1, 3'd0, 2, "R3 one byte below base");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 0, 32'h10FC, 4, 3'd1, 0, "R4 ends exactly at top");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 0, 32'h10FD, 4, 3'd1, 2, "R4 one byte past top");
    idle(1);
    drive(1, 32'h0, 32'hFFFF_FFFF, 5'h1F, 0, 32'hFFFF_FFFE, 4, 3'd0, 2, "R5 wrapping access");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 3, 32'h1010, 8, 3'd1, 3, "R6 sealed store");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 3, 32'h1010, 8, 3'd2, 3, "R6 sealed cap load");
    drive(1, 32'h1000, 32'h1100, 5'h04, 3, 32'h1010, 4, 3'd4, 0, "R6 sealed fetch allowed");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 3, 32'h1100, 4, 3'd0, 2, "R9 sealed and out of bounds");
    drive(1, 32'h1000, 32'h1100, 5'h00, 5, 32'h1010, 4, 3'd0, 3, "R9 sealed without perms");
    drive(1, 32'h1000, 32'h1100, 5'h01, 0, 32'h1010, 4, 3'd1, 4, "R7 store with load only");
    drive(1, 32'h1000, 32'h1100, 5'h02, 0, 32'h1010, 4, 3'd0, 4, "R7 load with store only");
    drive(1, 32'h1000, 32'h1100, 5'h03, 0, 32'h1010, 4, 3'd4, 4, "R7 fetch without execute");
    drive(1, 32'h1000, 32'h1100, 5'h04, 0, 32'h1010, 4, 3'd4, 0, "R7 fetch with execute");
    drive(1, 32'h1000, 32'h1100, 5'h1F, 0, 32'h1010, 4, 3'd5, 4, "R7 undefined op");
    drive(1, 32'h1000, 32'h1100, 5'h01, 0, 32'h1010, 16, 3'd2, 4, "R8 cap load lacks load-cap");
    drive(1, 32'h1000, 32'h1100, 5'h08, 0, 32'h1010, 16, 3'd2, 4, "R8 cap load lacks load");
    drive(1, 32'h1000, 32'h1100, 5'h09, 0, 32'h1010, 16, 3'd2, 0, "R8 cap load both bits");
    drive(1, 32'h1000, 32'h1100, 5'h02, 0, 32'h1010, 16, 3'd3, 4, "R8 cap store lacks store-cap");
    drive(1, 32'h1000, 32'h1100, 5'h10, 0, 32'h1010, 16, 3'd3, 4, "R8 cap store lacks store");
    drive(1, 32'h1000, 32'h1100, 5'h12, 0, 32'h1010, 16, 3'd3, 0, "R8 cap store both bits");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule